// File: doc/BRIEF.md
# Received Word Label and Source-Field Screen

This block sits behind a serial word decoder. Each time a complete 32-bit word arrives with its end-of-sequence strobe, the block decides whether to keep the word. A kept word goes into a 32-deep receive queue. A word that fails screening is thrown away.

Two checks can be switched on or off independently:

- **Label check.** The 8-bit label in bits 1 to 8 is compared in parallel against a 16-entry programmable table.
- **Source/destination check.** Bits 9 and 10 must equal two configured reference bits.

When both are on, a word is stored only if both pass.

The host fills the label table and reads it back through a sequential pointer while a programming mode is held. It drains the queue with a pop strobe and watches three flags: data present, half full and full. Each flag is also provided as an active-low pin.

Top module: `lbl_sdi_screen`

## Requirements
- R1: With `lbl_chk_en`=1, a word is accepted by the label check only if `word_in[7:0]` (word bits 1 to 8) equals at least one of the 16 table entries.
- R2: With `lbl_chk_en`=0, the label bits have no effect on whether a word is stored.
- R3: With `sdi_chk_en`=1, a word passes only if `word_in[8]`==`sdi_ref[0]` and `word_in[9]`==`sdi_ref[1]`. With `sdi_chk_en`=0, those bits are ignored.
- R4: A word presented with `word_valid`=1 is written only when every enabled check passes. A rejected word leaves the queue contents and flags unchanged.
- R5: While `lbl_prog`=1, each `lbl_wr` stores `lbl_wdata` into the entry at the pointer and advances it. The pointer is 0 when the mode is entered and wraps from 15 to 0.
- R6: While `lbl_prog`=1, `lbl_rdata` shows the entry at the pointer and each `lbl_rd` advances the pointer. Entries therefore read back in load order. With `lbl_prog`=0, `lbl_wr` and `lbl_rd` do not change the table.
- R7: Stored words leave in arrival order. The oldest word appears on `fifo_rdata` and is removed by `fifo_rd`. Up to 32 words are held.
- R8: `rdy` is 1 while at least one word is held and returns to 0 after the last word is popped.
- R9: `half` is 1 when 16 or more words are held and `full` is 1 when 32 are held. `rdy_n`, `half_n` and `full_n` are always the inverses of `rdy`, `half` and `full`.
- R10: A word that arrives while the queue is full is dropped and the held words are unchanged.
- R11: After reset, the queue is empty, all flags are 0, all active-low pins are 1, and every table entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | End-of-sequence strobe for `word_in` |
| word_in | input | 32 | Completed word; bit 0 is word bit 1 |
| lbl_chk_en | input | 1 | Enable label check |
| sdi_chk_en | input | 1 | Enable bits 9/10 check |
| sdi_ref | input | 2 | Reference for bits 9 (index 0) and 10 (index 1) |
| lbl_prog | input | 1 | Label table programming mode |
| lbl_wr | input | 1 | Table write strobe |
| lbl_wdata | input | 8 | Table write data |
| lbl_rd | input | 1 | Table read-advance strobe |
| lbl_rdata | output | 8 | Table entry at pointer |
| fifo_rd | input | 1 | Pop oldest word |
| fifo_rdata | output | 32 | Oldest held word |
| rdy | output | 1 | Queue not empty |
| half | output | 1 | At least half full |
| full | output | 1 | Queue full |
| rdy_n | output | 1 | Inverse of rdy |
| half_n | output | 1 | Inverse of half |
| full_n | output | 1 | Inverse of full |

## Verification
Assertions check the following on every cycle:

- Pointer stepping and wrap in the label table.
- A written entry lands at the previous pointer.
- The table holds still outside programming mode.
- A failing bits 9/10 compare or a full queue never produces a write.
- A full queue holds its contents.
- The flag ordering and the count step on a push.

Only the bench scenarios can show the rest: that the parallel label match picks exactly the programmed labels, that readback follows load order, that words leave in arrival order, and that the flags switch at exactly 16 and 32 words.

// File: rtl/screen_pkg.sv
package screen_pkg;
  typedef logic [31:0] word_t;
  typedef logic [7:0]  label_t;

  typedef struct packed {
    logic       lbl_en;
    logic       sdi_en;
    logic [1:0] sdi_ref;
  } chk_cfg_t;
endpackage

// File: rtl/screen_lbl_table.sv
module screen_lbl_table #(
  parameter int N_LABELS = 16,
  parameter int LBL_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_mode,
  input  logic             wr,
  input  logic [LBL_W-1:0] wdata,
  input  logic             rd,
  input  logic [LBL_W-1:0] probe,
  output logic             hit,
  output logic [LBL_W-1:0] rdata
);
  localparam int PW = (N_LABELS > 1) ? $clog2(N_LABELS) : 1;
  localparam logic [PW-1:0] LAST = PW'(N_LABELS - 1);

  logic [PW-1:0]                  ptr_q, ptr_d;
  logic [N_LABELS-1:0][LBL_W-1:0] tab_q, tab_d;
  logic                           step;
  logic [N_LABELS-1:0]            match_vec;

  assign step = prog_mode && (wr || rd);

  always_comb begin
    ptr_d = ptr_q;
    tab_d = tab_q;
    if (!prog_mode) begin
      ptr_d = '0;
    end else if (step) begin
      if (wr) tab_d[ptr_q] = wdata;
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      tab_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      if (step && wr) tab_q <= tab_d;
    end
  end

  // Parallel compare of the probe against every entry
  for (genvar g = 0; g < N_LABELS; g++) begin : g_cmp
    assign match_vec[g] = (tab_q[g] == probe);
  end

  assign hit   = |match_vec;
  assign rdata = tab_q[ptr_q];

  // R5
  lbl_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ptr_q != LAST) |=> ptr_q == PW'($past(ptr_q) + 1'b1));
  // R5
  lbl_ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ptr_q == LAST) |=> ptr_q == '0);
  // R5
  lbl_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && wr) |=> tab_q[$past(ptr_q)] == $past(wdata));
  // R6
  lbl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> $stable(tab_q));
endmodule

// File: rtl/screen_gate.sv
module screen_gate
  import screen_pkg::*;
(
  input  logic     valid,
  input  chk_cfg_t cfg,
  input  logic     lbl_hit,
  input  logic [1:0] sdi_bits,
  input  logic     q_full,
  output logic     push
);
  logic lbl_ok, sdi_ok;

  always_comb begin
    lbl_ok = !cfg.lbl_en || lbl_hit;
    sdi_ok = !cfg.sdi_en || (sdi_bits == cfg.sdi_ref);
    push   = valid && lbl_ok && sdi_ok && !q_full;
  end
endmodule

// File: rtl/screen_fifo.sv
module screen_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         rdy,
  output logic         half,
  output logic         full
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [AW-1:0]           wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]           cnt_q, cnt_d;
  logic                    do_wr, do_rd;

  assign full  = (cnt_q == CW'(DEPTH));
  assign half  = (cnt_q >= CW'(HALF));
  assign rdy   = (cnt_q != '0);
  assign rdata = mem_q[rp_q];

  always_comb begin
    do_wr = push && !full;
    do_rd = pop && rdy;
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_wr) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (do_rd) rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage without reset; write enable only
  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wp_q] <= wdata;
  end

  // R10
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full && $stable(wp_q) && $stable(rp_q));
  // R8
  fifo_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(1) && pop && !push) |=> !rdy);
  // R9
  fifo_flag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (half && rdy));
  // R7
  fifo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> cnt_q == CW'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/lbl_sdi_screen.sv
module lbl_sdi_screen
  import screen_pkg::*;
#(
  parameter int N_LABELS   = 16,
  parameter int FIFO_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_valid,
  input  logic [31:0] word_in,
  input  logic        lbl_chk_en,
  input  logic        sdi_chk_en,
  input  logic [1:0]  sdi_ref,
  input  logic        lbl_prog,
  input  logic        lbl_wr,
  input  logic [7:0]  lbl_wdata,
  input  logic        lbl_rd,
  output logic [7:0]  lbl_rdata,
  input  logic        fifo_rd,
  output logic [31:0] fifo_rdata,
  output logic        rdy,
  output logic        half,
  output logic        full,
  output logic        rdy_n,
  output logic        half_n,
  output logic        full_n
);
  chk_cfg_t cfg;
  logic     lbl_hit, push;

  assign cfg = '{lbl_en: lbl_chk_en, sdi_en: sdi_chk_en, sdi_ref: sdi_ref};

  screen_lbl_table #(.N_LABELS(N_LABELS), .LBL_W(8)) u_tab (
    .clk(clk), .rst_n(rst_n), .prog_mode(lbl_prog), .wr(lbl_wr),
    .wdata(lbl_wdata), .rd(lbl_rd), .probe(word_in[7:0]),
    .hit(lbl_hit), .rdata(lbl_rdata)
  );

  screen_gate u_gate (
    .valid(word_valid), .cfg(cfg), .lbl_hit(lbl_hit),
    .sdi_bits(word_in[9:8]), .q_full(full), .push(push)
  );

  screen_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(word_in),
    .pop(fifo_rd), .rdata(fifo_rdata), .rdy(rdy), .half(half), .full(full)
  );

  assign rdy_n  = ~rdy;
  assign half_n = ~half;
  assign full_n = ~full;

  // R3
  gate_sdi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdi_chk_en && (word_in[8] != sdi_ref[0] || word_in[9] != sdi_ref[1])) |-> !push);
  // R10
  gate_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R9
  pin_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_n != rdy) && (half_n != half) && (full_n != full));
endmodule

// File: tb/sim_lbl_sdi_screen.sv
`timescale 1ns/1ps
module sim_lbl_sdi_screen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        word_valid, lbl_chk_en, sdi_chk_en, lbl_prog, lbl_wr, lbl_rd, fifo_rd;
  logic [31:0] word_in;
  logic [1:0]  sdi_ref;
  logic [7:0]  lbl_wdata, lbl_rdata;
  logic [31:0] fifo_rdata;
  logic        rdy, half, full, rdy_n, half_n, full_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] exp_q[$];
  logic [7:0]  mtab[16];

  always #2.5 clk = ~clk;

  lbl_sdi_screen u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [21:0] p, input logic [1:0] s, input logic [7:0] l);
    return {p, s, l};
  endfunction

  task automatic flags(input string tag);
    int n = exp_q.size();
    chk(rdy  == (n != 0), {tag, " rdy"},  32'(rdy),  32'(n != 0));
    chk(half == (n >= 16), {tag, " R9 half"}, 32'(half), 32'(n >= 16));
    chk(full == (n == 32), {tag, " R9 full"}, 32'(full), 32'(n == 32));
    chk(rdy_n == !rdy && half_n == !half && full_n == !full, {tag, " R9 pins"},
        32'({rdy_n, half_n, full_n}), 32'({!rdy, !half, !full}));
  endtask

  // Driver: model decides acceptance, pushes expectation, drives the strobe
  task automatic send(input logic [31:0] w, input string tag);
    bit lok = 0, sok;
    for (int i = 0; i < 16; i++) if (mtab[i] == w[7:0]) lok = 1;
    lok = !lbl_chk_en || lok;
    sok = !sdi_chk_en || (w[8] == sdi_ref[0] && w[9] == sdi_ref[1]);
    word_in = w; word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
    if (lok && sok && exp_q.size() < 32) exp_q.push_back(w);
    flags(tag);
  endtask

  // Monitor: compare the head against the scoreboard, then pop
  task automatic pop_one(input string tag);
    logic [31:0] e = exp_q.pop_front();
    chk(rdy == 1'b1, {tag, " R8 rdy before pop"}, 32'(rdy), 32'd1);
    chk(fifo_rdata == e, {tag, " R7 order"}, fifo_rdata, e);
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
  endtask

  task automatic drain(input string tag);
    while (exp_q.size() > 0) pop_one(tag);
    chk(rdy == 1'b0 && rdy_n == 1'b1, {tag, " R8 rdy cleared"}, 32'(rdy), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; word_valid = 0; word_in = '0; lbl_chk_en = 0; sdi_chk_en = 0;
    sdi_ref = 2'b00; lbl_prog = 0; lbl_wr = 0; lbl_rd = 0; lbl_wdata = '0; fifo_rd = 0;
    for (int i = 0; i < 16; i++) mtab[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    flags("R11");
    lbl_prog = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      chk(lbl_rdata == 8'h00, "R11 table zero", 32'(lbl_rdata), 32'd0);
      lbl_rd = 1'b1; @(negedge clk); lbl_rd = 1'b0;
    end
    lbl_prog = 1'b0;
    @(negedge clk);

    // R5 load 16 labels in sequence
    lbl_prog = 1'b1;
    for (int i = 0; i < 16; i++) begin
      mtab[i] = 8'h21 + 8'(i * 7);
      lbl_wdata = mtab[i]; lbl_wr = 1'b1;
      @(negedge clk);
    end
    lbl_wr = 1'b0; lbl_prog = 1'b0;
    @(negedge clk);

    // R6 strobes outside the mode leave the table alone
    lbl_wdata = 8'hEE; lbl_wr = 1'b1; lbl_rd = 1'b1;
    @(negedge clk);
    lbl_wr = 1'b0; lbl_rd = 1'b0;

    // R5 R6 readback from entry 0 in load order, then wrap
    lbl_prog = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 17; i++) begin
      chk(lbl_rdata == mtab[i % 16], "R6 readback order / R5 wrap",
          32'(lbl_rdata), 32'(mtab[i % 16]));
      lbl_rd = 1'b1; @(negedge clk); lbl_rd = 1'b0;
    end
    lbl_prog = 1'b0;
    @(negedge clk);

    // R2 both checks off: any label is stored
    send(mk(22'h00001, 2'b11, 8'h00), "R2");
    send(mk(22'h00002, 2'b01, 8'hFF), "R2");
    send(mk(22'h00003, 2'b00, 8'h21), "R2");
    drain("R2");

    // R1 label check only
    lbl_chk_en = 1'b1;
    send(mk(22'h00010, 2'b10, 8'h21), "R1 hit first");
    send(mk(22'h00011, 2'b10, 8'h22), "R1 miss");
    send(mk(22'h00012, 2'b00, 8'h21 + 8'd105), "R1 hit last");
    send(mk(22'h00013, 2'b11, 8'h00), "R1 miss zero");
    send(mk(22'h00014, 2'b01, 8'h21 + 8'd49), "R1 hit mid");
    drain("R1");

    // R3 bits 9/10 check only (bit 9 = ref[0], bit 10 = ref[1])
    lbl_chk_en = 1'b0; sdi_chk_en = 1'b1; sdi_ref = 2'b10;
    send(mk(22'h00020, 2'b10, 8'h00), "R3 match");
    send(mk(22'h00021, 2'b01, 8'h00), "R3 swapped");
    send(mk(22'h00022, 2'b00, 8'h00), "R3 zero");
    send(mk(22'h00023, 2'b11, 8'h00), "R3 ones");
    drain("R3");

    // R4 both checks
    lbl_chk_en = 1'b1; sdi_ref = 2'b01;
    send(mk(22'h00030, 2'b01, 8'h28), "R4 both pass");
    send(mk(22'h00031, 2'b10, 8'h28), "R4 sdi fail");
    send(mk(22'h00032, 2'b01, 8'h29), "R4 label fail");
    send(mk(22'h00033, 2'b11, 8'h05), "R4 both fail");
    drain("R4");

    // R9 R10 fill to 32, then an extra word is dropped
    lbl_chk_en = 1'b0; sdi_chk_en = 1'b0;
    for (int i = 0; i < 32; i++) send(mk(22'(i + 'h100), 2'(i), 8'(i)), "R9 fill");
    send(mk(22'h3FFFF, 2'b11, 8'hAA), "R10 overflow");
    chk(fifo_rdata == exp_q[0], "R10 head unchanged", fifo_rdata, exp_q[0]);
    drain("R10 R7");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule